// File: doc/BRIEF.md
# Level-Sensitive Interrupt Register Front End

This block is the software-visible register file of an interrupt controller that serves up to three banks of 32 request lines. Every line is treated as a plain level: a line is raw-pending while its input is high or while software has set its software-request bit, and nothing is latched from edges. Software masks lines through atomic set and clear registers, reads pending status separately for the normal and the fast class, and programs a 6-bit priority plus a fast-class select for each line.

The per-line priorities, class selects and pending vectors are driven out to a shared priority arbiter, which lies outside this block; the arbiter's winning line codes come back in and are readable as sorted codes. Two request outputs, one per class, are raised through an agreement handshake: a class asserts once when it is armed and sees pending work, then holds until software re-arms it through the control register. A global mask bit blocks new assertions, and a configuration bit performs a soft reset of the whole controller.

Top module: `lvl_intc_regs`

## Requirements
- R1: After reset every mask bit is 1, software bits, class selects, priorities, global mask, autoidle and idle bits are 0, both request outputs are low, offset 0x14 reads 1 and offset 0x00 reads the REVISION parameter.
- R2: Offset 0x10 bit 0 is a readable autoidle bit; writing 1 to bit 1 returns all state to its reset value at that clock edge. Offset 0x50 holds two writable bits; higher written bits are dropped.
- R3: Bank b occupies 0x80 + 0x20*b. Offset +0x00 reads the input levels; a write to +0x10 ORs ones into the software bits, which read back there; a write to +0x14 clears the software bits written as ones and reads 0. A line is raw-pending when its input or its software bit is 1.
- R4: Bank offset +0x04 is the mask, read and write; writing ones to +0x08 clears mask bits and writing ones to +0x0C sets them; both read as 0.
- R5: Bank offset +0x18 reads raw & ~mask & ~select and +0x1C reads raw & ~mask & select, where select is the per-line fast-class bit.
- R6: Line n has a register at 0x100 + 4*n with priority in bits 7:2 and the fast-class select in bit 0 (bit 1 reads 0); registers for lines at or beyond the line count ignore writes and read 0. Priorities and selects are driven to the arbiter outputs.
- R7: A class request output rises at the clock edge after a cycle in which the class is armed, some line of that class is pending and the global mask is clear; the class then disarms and the output stays high even if pending work disappears.
- R8: Control register 0x48 bit 2 is the global mask, readable there; while it is 1 no request output rises.
- R9: Writing 1 to control bit 0 (normal class) or bit 1 (fast class) drops that request output at that edge and re-arms the class.
- R10: Offsets 0x40 and 0x44 read the arbiter's normal-class and fast-class winning codes.
- R11: Writes to read-only offsets (revision, status, sorted codes, raw input, pending) and to unmapped or protection offsets change nothing; the protection offset, nonexistent banks and other unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 96 | Level request lines, bank-major |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| arb_irq_code | input | 7 | Winning normal-class line from the arbiter |
| arb_fiq_code | input | 7 | Winning fast-class line from the arbiter |
| irq_req | output | 1 | Normal-class request |
| fiq_req | output | 1 | Fast-class request |
| line_prio_flat | output | 576 | Six-bit priority of each line, line n at bits 6n+5:6n |
| line_fiq_sel | output | 96 | Fast-class select per line |
| pend_irq_vec | output | 96 | Unmasked normal-class pending lines |
| pend_fiq_vec | output | 96 | Unmasked fast-class pending lines |

## Verification
The assertions watch, on every cycle, the mask set and clear and software clear effects, the rule that a request output only rises after armed pending work with the global mask clear, the blocking effect of the global mask, the drop on re-arm, and the state after a soft reset. Address decoding, read-back of each register, the boundary between implemented and absent lines and banks, ignored writes to read-only offsets, and the latched behaviour of a request after its pending line falls can only be shown by the bench's scenarios, which run a behavioural model alongside and compare both request outputs each clock.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;

    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int PRIO_W     = 6;
    localparam int BANK_LINES = 32;
    localparam int LIDX_W     = 7;

    typedef enum logic [3:0] {
        K_NONE, K_REV, K_CFG, K_STAT, K_SIRQ, K_SFIQ,
        K_CTRL, K_PROT, K_IDLE, K_BANK, K_LINE
    } reg_kind_e;

    // Order of bank sub-registers is decoded from address bits 4:2
    typedef enum logic [2:0] {
        B_RAW  = 3'd0,
        B_MASK = 3'd1,
        B_MCLR = 3'd2,
        B_MSET = 3'd3,
        B_SSET = 3'd4,
        B_SCLR = 3'd5,
        B_PIRQ = 3'd6,
        B_PFIQ = 3'd7
    } bank_sub_e;

    typedef struct packed {
        reg_kind_e         kind;
        logic [1:0]        bank;
        bank_sub_e         sub;
        logic [LIDX_W-1:0] line;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_dec_t          d;
        logic [ADDR_W-1:0] rel;
        rel    = a - ADDR_W'(12'h100);
        d.kind = K_NONE;
        d.bank = a[6:5];
        d.sub  = bank_sub_e'(a[4:2]);
        d.line = rel[LIDX_W+1:2];
        if (a[1:0] != 2'b00) begin
            d.kind = K_NONE;
        end else if (a[11:7] == 5'b00001) begin
            d.kind = K_BANK;
        end else if (a >= ADDR_W'(12'h100) && a <= ADDR_W'(12'h2FC)) begin
            d.kind = K_LINE;
        end else begin
            case (a)
                12'h000: d.kind = K_REV;
                12'h010: d.kind = K_CFG;
                12'h014: d.kind = K_STAT;
                12'h040: d.kind = K_SIRQ;
                12'h044: d.kind = K_SFIQ;
                12'h048: d.kind = K_CTRL;
                12'h04C: d.kind = K_PROT;
                12'h050: d.kind = K_IDLE;
                default: d.kind = K_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/lvl_intc_bank.sv
module lvl_intc_bank
    import lvl_intc_pkg::*;
#(
    parameter int LINES = BANK_LINES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  bank_sub_e        sub,
    input  logic [LINES-1:0] wdata,
    input  logic [LINES-1:0] lvl_in,
    input  logic [LINES-1:0] fiq_sel,
    output logic [LINES-1:0] pend_irq,
    output logic [LINES-1:0] pend_fiq,
    output logic [LINES-1:0] rdata
);

    logic [LINES-1:0] mask_q;
    logic [LINES-1:0] swi_q;
    logic [LINES-1:0] raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            swi_q  <= '0;
        end else if (wr_en) begin
            case (sub)
                B_MASK:  mask_q <= wdata;
                B_MCLR:  mask_q <= mask_q & ~wdata;
                B_MSET:  mask_q <= mask_q | wdata;
                B_SSET:  swi_q  <= swi_q | wdata;
                B_SCLR:  swi_q  <= swi_q & ~wdata;
                default: ;
            endcase
        end
    end

    assign raw      = lvl_in | swi_q;
    assign pend_irq = raw & ~mask_q & ~fiq_sel;
    assign pend_fiq = raw & ~mask_q & fiq_sel;

    always_comb begin
        case (sub)
            B_RAW:   rdata = lvl_in;
            B_MASK:  rdata = mask_q;
            B_SSET:  rdata = swi_q;
            B_PIRQ:  rdata = pend_irq;
            B_PFIQ:  rdata = pend_fiq;
            default: rdata = '0;
        endcase
    end

    // R4
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sub == B_MSET) |=> ((mask_q & $past(wdata)) == $past(wdata)));
    // R4
    mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sub == B_MCLR) |=> ((mask_q & $past(wdata)) == '0));
    // R3
    swi_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sub == B_SCLR) |=> ((swi_q & $past(wdata)) == '0));

endmodule

// File: rtl/lvl_intc_line_cfg.sv
module lvl_intc_line_cfg
    import lvl_intc_pkg::*;
#(
    parameter int NLINE = 96
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [LIDX_W-1:0]       idx,
    input  logic [PRIO_W-1:0]       prio_in,
    input  logic                    fsel_in,
    output logic [NLINE*PRIO_W-1:0] prio_flat,
    output logic [NLINE-1:0]        fsel,
    output logic [PRIO_W+1:0]       rdata
);

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        logic [PRIO_W-1:0] prio_q;
        logic              fsel_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                prio_q <= '0;
                fsel_q <= 1'b0;
            end else if (wr_en && idx == LIDX_W'(g)) begin
                prio_q <= prio_in;
                fsel_q <= fsel_in;
            end
        end
        assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q;
        assign fsel[g]                       = fsel_q;
    end

    always_comb begin
        rdata = '0;
        for (int n = 0; n < NLINE; n++) begin
            if (idx == LIDX_W'(n))
                rdata = {prio_flat[n*PRIO_W +: PRIO_W], 1'b0, fsel[n]};
        end
    end

endmodule

// File: rtl/lvl_intc_agree.sv
module lvl_intc_agree (
    input  logic clk,
    input  logic rst,
    input  logic any_pend,
    input  logic gmask,
    input  logic rearm,
    output logic req
);

    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b1;
            req     <= 1'b0;
        end else if (rearm) begin
            armed_q <= 1'b1;
            req     <= 1'b0;
        end else if (armed_q && any_pend && !gmask) begin
            armed_q <= 1'b0;
            req     <= 1'b1;
        end
    end

    // R7
    rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> $past(any_pend && !gmask));
    // R8
    gmask_block_chk: assert property (@(posedge clk) disable iff (rst)
        (gmask && !req) |=> !req);
    // R9
    rearm_drop_chk: assert property (@(posedge clk) disable iff (rst)
        rearm |=> !req);

endmodule

// File: rtl/lvl_intc_regs.sv
module lvl_intc_regs
    import lvl_intc_pkg::*;
#(
    parameter int          NBANK    = 3,
    parameter logic [7:0]  REVISION = 8'h21,
    localparam int         NLINE    = NBANK * BANK_LINES,
    localparam int         CODE_W   = $clog2(NLINE)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NLINE-1:0]        line_in,
    input  logic                    reg_wr,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    input  logic [CODE_W-1:0]       arb_irq_code,
    input  logic [CODE_W-1:0]       arb_fiq_code,
    output logic                    irq_req,
    output logic                    fiq_req,
    output logic [NLINE*PRIO_W-1:0] line_prio_flat,
    output logic [NLINE-1:0]        line_fiq_sel,
    output logic [NLINE-1:0]        pend_irq_vec,
    output logic [NLINE-1:0]        pend_fiq_vec
);

    localparam logic [2:0] NBANK_L = 3'(NBANK);
    localparam logic [7:0] NLINE_L = 8'(NLINE);

    reg_dec_t   dec;
    logic       bank_ok, line_ok;
    logic       soft_rst, rst_all;
    logic       autoidle_q, gmask_q;
    logic [1:0] idle_q;
    logic       rearm_irq, rearm_fiq;
    logic [BANK_LINES-1:0] bank_rd [NBANK];
    logic [PRIO_W+1:0]     line_rd;

    assign dec      = decode_addr(reg_addr);
    assign bank_ok  = {1'b0, dec.bank} < NBANK_L;
    assign line_ok  = {1'b0, dec.line} < NLINE_L;
    assign soft_rst = reg_wr && dec.kind == K_CFG && reg_wdata[1];
    assign rst_all  = rst || soft_rst;

    always_ff @(posedge clk) begin
        if (rst_all) begin
            autoidle_q <= 1'b0;
            gmask_q    <= 1'b0;
            idle_q     <= 2'b00;
        end else if (reg_wr) begin
            case (dec.kind)
                K_CFG:   autoidle_q <= reg_wdata[0];
                K_CTRL:  gmask_q    <= reg_wdata[2];
                K_IDLE:  idle_q     <= reg_wdata[1:0];
                default: ;
            endcase
        end
    end

    lvl_intc_line_cfg #(.NLINE(NLINE)) line_cfg_i (
        .clk      (clk),
        .rst      (rst_all),
        .wr_en    (reg_wr && dec.kind == K_LINE && line_ok),
        .idx      (dec.line),
        .prio_in  (reg_wdata[PRIO_W+1:2]),
        .fsel_in  (reg_wdata[0]),
        .prio_flat(line_prio_flat),
        .fsel     (line_fiq_sel),
        .rdata    (line_rd)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        lvl_intc_bank #(.LINES(BANK_LINES)) bank_i (
            .clk     (clk),
            .rst     (rst_all),
            .wr_en   (reg_wr && dec.kind == K_BANK && dec.bank == 2'(b)),
            .sub     (dec.sub),
            .wdata   (reg_wdata[BANK_LINES-1:0]),
            .lvl_in  (line_in[b*BANK_LINES +: BANK_LINES]),
            .fiq_sel (line_fiq_sel[b*BANK_LINES +: BANK_LINES]),
            .pend_irq(pend_irq_vec[b*BANK_LINES +: BANK_LINES]),
            .pend_fiq(pend_fiq_vec[b*BANK_LINES +: BANK_LINES]),
            .rdata   (bank_rd[b])
        );
    end

    assign rearm_irq = reg_wr && dec.kind == K_CTRL && reg_wdata[0];
    assign rearm_fiq = reg_wr && dec.kind == K_CTRL && reg_wdata[1];

    lvl_intc_agree irq_agree_i (
        .clk     (clk),
        .rst     (rst_all),
        .any_pend(|pend_irq_vec),
        .gmask   (gmask_q),
        .rearm   (rearm_irq),
        .req     (irq_req)
    );

    lvl_intc_agree fiq_agree_i (
        .clk     (clk),
        .rst     (rst_all),
        .any_pend(|pend_fiq_vec),
        .gmask   (gmask_q),
        .rearm   (rearm_fiq),
        .req     (fiq_req)
    );

    always_comb begin
        reg_rdata = '0;
        case (dec.kind)
            K_REV:  reg_rdata = DATA_W'(REVISION);
            K_CFG:  reg_rdata = DATA_W'(autoidle_q);
            K_STAT: reg_rdata = DATA_W'(1);
            K_SIRQ: reg_rdata = DATA_W'(arb_irq_code);
            K_SFIQ: reg_rdata = DATA_W'(arb_fiq_code);
            K_CTRL: reg_rdata = DATA_W'({gmask_q, 2'b00});
            K_IDLE: reg_rdata = DATA_W'(idle_q);
            K_LINE: if (line_ok) reg_rdata = DATA_W'(line_rd);
            K_BANK: begin
                for (int b = 0; b < NBANK; b++) begin
                    if (bank_ok && dec.bank == 2'(b))
                        reg_rdata = DATA_W'(bank_rd[b]);
                end
            end
            default: reg_rdata = '0;
        endcase
    end

    // R2
    soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!irq_req && !fiq_req && !gmask_q && idle_q == 2'b00
                      && pend_irq_vec == '0 && pend_fiq_vec == '0));

endmodule

// File: tb/lvl_intc_regs_tb_top.sv
`timescale 1ns/1ps
module lvl_intc_regs_tb_top;

    localparam int NB = 3;
    localparam int NL = 96;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] line_in = '0;
    logic          reg_wr = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [6:0]    arb_irq_code = 7'h2A;
    logic [6:0]    arb_fiq_code = 7'h15;
    logic          irq_req, fiq_req;
    logic [NL*6-1:0] line_prio_flat;
    logic [NL-1:0] line_fiq_sel, pend_irq_vec, pend_fiq_vec;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit run   = 1'b0;

    always #4 clk = ~clk;

    lvl_intc_regs dut_i (
        .clk(clk), .rst(rst), .line_in(line_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .arb_irq_code(arb_irq_code), .arb_fiq_code(arb_fiq_code),
        .irq_req(irq_req), .fiq_req(fiq_req), .line_prio_flat(line_prio_flat),
        .line_fiq_sel(line_fiq_sel), .pend_irq_vec(pend_irq_vec),
        .pend_fiq_vec(pend_fiq_vec)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_mask [NB];
    logic [31:0] m_swi  [NB];
    logic [NL-1:0] m_fsel;
    int          m_prio [NL];
    bit          m_gm, m_auto;
    bit [1:0]    m_idle;
    bit          m_arm [2];
    bit          m_req [2];

    task automatic m_reset();
        for (int b = 0; b < NB; b++) begin
            m_mask[b] = 32'hFFFF_FFFF;
            m_swi[b]  = 32'h0;
        end
        m_fsel = '0;
        for (int n = 0; n < NL; n++) m_prio[n] = 0;
        m_gm = 0; m_auto = 0; m_idle = 0;
        m_arm[0] = 1; m_arm[1] = 1;
        m_req[0] = 0; m_req[1] = 0;
    endtask

    function automatic logic [31:0] m_pend(int b, bit fast);
        logic [31:0] raw, sel;
        raw = line_in[b*32 +: 32] | m_swi[b];
        sel = m_fsel[b*32 +: 32];
        return fast ? (raw & ~m_mask[b] & sel) : (raw & ~m_mask[b] & ~sel);
    endfunction

    function automatic logic [31:0] m_read(int a);
        int b, off, n;
        if (a >= 'h80 && a < 'h80 + 32*NB) begin
            b = (a - 'h80) / 32; off = (a - 'h80) % 32;
            case (off)
                'h00: return line_in[b*32 +: 32];
                'h04: return m_mask[b];
                'h10: return m_swi[b];
                'h18: return m_pend(b, 0);
                'h1C: return m_pend(b, 1);
                default: return 0;
            endcase
        end
        if (a >= 'h100 && a < 'h100 + 4*NL && a % 4 == 0) begin
            n = (a - 'h100) / 4;
            return 32'((m_prio[n] << 2) | int'(m_fsel[n]));
        end
        case (a)
            'h00: return 32'h21;
            'h10: return 32'(m_auto);
            'h14: return 1;
            'h40: return 32'(arb_irq_code);
            'h44: return 32'(arb_fiq_code);
            'h48: return 32'(m_gm) << 2;
            'h50: return 32'(m_idle);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_reset();
        end else begin
            bit pany [2];
            int a, b, off, n;
            a = int'(reg_addr);
            for (int c = 0; c < 2; c++) begin
                pany[c] = 0;
                for (int k = 0; k < NB; k++) if (m_pend(k, c != 0) != 0) pany[c] = 1;
            end
            for (int c = 0; c < 2; c++) begin
                if (reg_wr && a == 'h48 && reg_wdata[c]) begin
                    m_req[c] = 0; m_arm[c] = 1;
                end else if (m_arm[c] && pany[c] && !m_gm) begin
                    m_req[c] = 1; m_arm[c] = 0;
                end
            end
            if (reg_wr) begin
                if (a == 'h10 && reg_wdata[1]) begin
                    m_reset();
                end else if (a >= 'h80 && a < 'h80 + 32*NB) begin
                    b = (a - 'h80) / 32; off = (a - 'h80) % 32;
                    case (off)
                        'h04: m_mask[b] = reg_wdata;
                        'h08: m_mask[b] = m_mask[b] & ~reg_wdata;
                        'h0C: m_mask[b] = m_mask[b] | reg_wdata;
                        'h10: m_swi[b]  = m_swi[b] | reg_wdata;
                        'h14: m_swi[b]  = m_swi[b] & ~reg_wdata;
                        default: ;
                    endcase
                end else if (a >= 'h100 && a < 'h100 + 4*NL && a % 4 == 0) begin
                    n = (a - 'h100) / 4;
                    m_prio[n] = int'(reg_wdata[7:2]);
                    m_fsel[n] = reg_wdata[0];
                end else begin
                    case (a)
                        'h10: m_auto = reg_wdata[0];
                        'h48: m_gm   = reg_wdata[2];
                        'h50: m_idle = reg_wdata[1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (run) begin
            chk("R7 irq_req vs model", 32'(irq_req), 32'(m_req[0]));
            chk("R7 fiq_req vs model", 32'(fiq_req), 32'(m_req[1]));
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = 12'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input int a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = 12'(a);
        #2;
        chk(tag, reg_rdata, exp);
        chk({tag, " model"}, reg_rdata, m_read(a));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run = 1'b1;

        // R1 reset state
        chk("R1 irq low", 32'(irq_req), 0);
        chk("R1 fiq low", 32'(fiq_req), 0);
        rd("R1 status", 'h14, 1);
        rd("R1 revision", 'h00, 32'h21);
        rd("R1 mask bank0", 'h84, 32'hFFFF_FFFF);
        rd("R1 control", 'h48, 0);

        // R6 per-line registers and boundary
        wr('h100 + 4*5, (32'h2A << 2) | 32'h3);
        rd("R6 line5", 'h100 + 4*5, 32'hA9);
        chk("R6 prio out", 32'(line_prio_flat[5*6 +: 6]), 32'h2A);
        chk("R6 fsel out", 32'(line_fiq_sel[5]), 1);
        wr('h100 + 4*95, 32'hFF);
        rd("R6 line95", 'h100 + 4*95, 32'hFD);
        wr('h100 + 4*100, 32'hFD);
        rd("R6 line100 absent", 'h100 + 4*100, 0);
        wr('h100 + 4*5, 0);

        // R3 R5 R7 normal class
        line_in[3] = 1'b1;
        rd("R3 raw input", 'h80, 32'h8);
        rd("R5 masked pend", 'h98, 0);
        idle(3);
        chk("R7 masked no irq", 32'(irq_req), 0);
        wr('h88, 32'h8);
        rd("R4 mask after clear", 'h84, 32'hFFFF_FFF7);
        rd("R4 clear reads 0", 'h88, 0);
        rd("R5 pend irq", 'h98, 32'h8);
        rd("R5 pend fiq", 'h9C, 0);
        chk("R7 irq raised", 32'(irq_req), 1);
        line_in[3] = 1'b0;
        idle(2);
        rd("R5 pend gone", 'h98, 0);
        chk("R7 irq held", 32'(irq_req), 1);
        wr('h48, 32'h1);
        chk("R9 irq dropped", 32'(irq_req), 0);
        idle(3);
        chk("R9 stays low", 32'(irq_req), 0);

        // R3 R5 fast class via software bit, line 36
        wr('h100 + 4*36, 32'h1);
        wr('hB0, 32'h10);
        rd("R3 swi readback", 'hB0, 32'h10);
        rd("R3 raw is inputs", 'hA0, 0);
        wr('hA8, 32'h10);
        rd("R5 pend fiq b1", 'hBC, 32'h10);
        rd("R5 pend irq b1", 'hB8, 0);
        chk("R7 fiq raised", 32'(fiq_req), 1);
        chk("R7 irq untouched", 32'(irq_req), 0);
        wr('hB4, 32'h10);
        rd("R3 swi cleared", 'hB0, 0);
        rd("R3 clear reads 0", 'hB4, 0);
        rd("R5 fiq pend gone", 'hBC, 0);
        wr('h48, 32'h2);
        chk("R9 fiq dropped", 32'(fiq_req), 0);

        // R8 global mask
        wr('h48, 32'h4);
        rd("R8 gmask read", 'h48, 32'h4);
        line_in[3] = 1'b1;
        idle(4);
        chk("R8 blocked", 32'(irq_req), 0);
        wr('h48, 32'h0);
        idle(1);
        chk("R8 released", 32'(irq_req), 1);

        // R4 mask set
        wr('h8C, 32'h8);
        rd("R4 mask set", 'h84, 32'hFFFF_FFFF);
        rd("R4 set reads 0", 'h8C, 0);
        wr('h84, 32'h0000_FFFF);
        rd("R4 mask write", 'h84, 32'h0000_FFFF);
        wr('h84, 32'hFFFF_FFFF);

        // R10 sorted codes
        rd("R10 irq code", 'h40, 32'h2A);
        rd("R10 fiq code", 'h44, 32'h15);

        // R11 ignored writes
        wr('h14, 32'h0);
        rd("R11 status", 'h14, 1);
        wr('h00, 32'hFF);
        rd("R11 revision", 'h00, 32'h21);
        wr('h40, 32'h7F);
        rd("R11 sorted", 'h40, 32'h2A);
        wr('h80, 32'h0);
        rd("R11 raw", 'h80, 32'h8);
        wr('h4C, 32'h1);
        rd("R11 protection", 'h4C, 0);
        rd("R11 absent bank", 'hE4, 0);
        rd("R11 unmapped", 'h20, 0);

        // R2 config, idle, soft reset
        wr('h10, 32'h1);
        rd("R2 autoidle", 'h10, 1);
        wr('h50, 32'h7);
        rd("R2 idle two bits", 'h50, 3);
        wr('h100 + 4*7, 32'h5C);
        wr('hC8, 32'h1);
        rd("R2 pre mask", 'hC4, 32'hFFFF_FFFE);
        wr('h10, 32'h2);
        chk("R2 irq cleared", 32'(irq_req), 0);
        rd("R2 mask reset", 'hC4, 32'hFFFF_FFFF);
        rd("R2 autoidle reset", 'h10, 0);
        rd("R2 idle reset", 'h50, 0);
        rd("R2 line reset", 'h100 + 4*7, 0);
        line_in[3] = 1'b0;
        idle(3);

        run = 1'b0;
        finish_up();
    end

endmodule